// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator with Genlock Reset

The block produces the running phase of a colour subcarrier for a video encoder that runs from a single 27 MHz clock. A 32-bit phase accumulator adds a programmable frequency word on every clock. The top ten bits of the accumulator, plus a programmable phase offset, are sent to a sine/cosine lookup table that lives outside this block. The host sets up the frequency word, the offset and the pin mode through a byte-wide register write port.

An external pin can bring the accumulator back to the field-0 phase, which is zero. Two mode bits decide what the pin does. When the pin is configured as an input and its role is subcarrier reset, a low-to-high transition on it clears the accumulator. The pin passes through two synchroniser flops and an edge detector first.

A small controller holds the genlock state. It has three states:
- `GL_OFF`: the pin is ignored.
- `GL_ARMED`: the controller waits for a rising edge.
- `GL_CLEAR`: a one-cycle state that zeroes the accumulator on the next edge.

Its transitions are:
- OFF→ARMED when reset mode becomes enabled.
- ARMED→OFF when reset mode is disabled.
- ARMED→CLEAR on a synchronised rising edge.
- CLEAR→ARMED or CLEAR→OFF on the following cycle, depending on the mode.

Top module: `sc_phase_gen`

## Requirements
- R1: After a hardware reset the outputs and registers are in these states:
  - `phase_out` is 0 and the accumulator is 0.
  - The active frequency word is 32'h21F07C1F, the NTSC subcarrier at 27 MHz.
  - The offset is 0 and the mode register is 0.
  - After the first clock edge following reset release, `phase_out` is 135.
- R2: On every clock edge that is not a genlock clear, the accumulator adds the active frequency word, modulo 2^32. `phase_out` equals the accumulator's bits 31:22 plus the offset shifted left by 2, modulo 1024.
- R3: Write addresses 0, 1 and 2 hold bits 7:0, 15:8 and 23:16 of a staged frequency word. A write to address 3 supplies bits 31:24 and commits all four bytes to the active word on its write edge. The first addition that uses the new word happens on the next edge.
- R4: Writes to addresses 0 to 2 without a write to address 3 do not change the rate at which the accumulator advances.
- R5: Address 4 holds the 8-bit phase offset. A write to it changes `phase_out` from the write edge onward and does not alter the accumulator.
- R6: Address 5 is the mode register:
  - Bit 0 = 1 makes the pin an input.
  - Bit 1 selects the pin's role: 0 is subcarrier reset, 1 is another role that never resets the accumulator.
  - Reset mode takes effect one cycle after the write.
- R7: In reset mode, suppose the pin is first sampled high at edge E0 after being low. The accumulator is then 0 right after edge E0+3, so `phase_out` equals the offset shifted left by 2. It advances again from edge E0+4.
- R8: The pin has no effect in any of these cases:
  - when bit 0 of the mode register is 0;
  - when bit 1 of the mode register is 1;
  - on falling edges;
  - while the pin is held at a steady level.
- R9: A genlock clear and a frequency commit on the same edge both take effect. The accumulator becomes 0, and the new word is used from the next edge.
- R10: Writes to addresses 6 and 7 have no effect on `phase_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| sc_pin | input | 1 | Asynchronous genlock pin |
| phase_out | output | 10 | Subcarrier phase sent to the sine/cosine table |

## Verification
A genlock clear can land on the same edge as a commit of the most significant frequency byte, and it can also land on the same edge as a phase-offset write. The bench provokes this with a directed case. It raises the pin three edges before a write to address 3, so that the clear and the commit share the same edge. Random stimulus then mixes pin toggles with register writes to reach other coincidences. The result is judged against a per-cycle bench model built from the requirements. That model zeroes the accumulator on the shared edge and applies the committed word only on the next add.

// File: rtl/sc_pkg.sv
package sc_pkg;
    typedef enum logic [1:0] {
        GL_OFF   = 2'd0,
        GL_ARMED = 2'd1,
        GL_CLEAR = 2'd2
    } gl_state_t;
endpackage

// File: rtl/sc_freq_regs.sv
module sc_freq_regs #(
    parameter int ACC_W = 32,
    parameter int OFS_W = 8,
    parameter int ADDR_W = 3,
    parameter logic [ACC_W-1:0] FREQ_RST = 32'h21F07C1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [ACC_W-1:0]  freq_word,
    output logic [OFS_W-1:0]  ofs,
    output logic              pin_in_en,
    output logic              role_sel
);
    localparam int NBYTES    = ACC_W / 8;
    localparam int STG_W     = ACC_W - 8;
    localparam int ADDR_MSB  = NBYTES - 1;
    localparam int ADDR_OFS  = NBYTES;
    localparam int ADDR_MODE = NBYTES + 1;

    logic [STG_W-1:0] stage_q;
    logic [ACC_W-1:0] freq_q;
    logic [OFS_W-1:0] ofs_q;
    logic [1:0]       mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= FREQ_RST[STG_W-1:0];
        end else if (wr_en) begin
            for (int i = 0; i < NBYTES - 1; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    stage_q[i*8 +: 8] <= wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_q <= FREQ_RST;
        end else if (wr_en && wr_addr == ADDR_W'(ADDR_MSB)) begin
            freq_q <= {wr_data, stage_q};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_OFS)) begin
                ofs_q <= wr_data[OFS_W-1:0];
            end
            if (wr_addr == ADDR_W'(ADDR_MODE)) begin
                mode_q <= wr_data[1:0];
            end
        end
    end

    assign freq_word = freq_q;
    assign ofs       = ofs_q;
    assign pin_in_en = mode_q[0];
    assign role_sel  = mode_q[1];
endmodule

// File: rtl/sc_genlock_ctl.sv
module sc_genlock_ctl #(
    parameter int SYNC_N = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sc_pin,
    input  logic                pin_in_en,
    input  logic                role_sel,
    output logic                clr,
    output sc_pkg::gl_state_t   state
);
    import sc_pkg::*;

    logic [SYNC_N:0] sh_q;
    logic            rise;
    logic            rst_mode;
    gl_state_t       state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SYNC_N-1:0], sc_pin};
        end
    end

    assign rise     = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
    assign rst_mode = pin_in_en & ~role_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GL_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GL_OFF: begin
                if (rst_mode) state_d = GL_ARMED;
            end
            GL_ARMED: begin
                if (!rst_mode)  state_d = GL_OFF;
                else if (rise)  state_d = GL_CLEAR;
            end
            GL_CLEAR: begin
                state_d = rst_mode ? GL_ARMED : GL_OFF;
            end
            default: state_d = GL_OFF;
        endcase
    end

    always_comb begin
        clr = (state_q == GL_CLEAR);
    end

    assign state = state_q;
endmodule

// File: rtl/sc_phase_acc.sv
module sc_phase_acc #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 10,
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [ACC_W-1:0] freq_word,
    input  logic [OFS_W-1:0] ofs,
    output logic [ACC_W-1:0] acc,
    output logic [PH_W-1:0]  phase
);
    localparam int SH = PH_W - OFS_W;

    logic [ACC_W-1:0] acc_q;
    logic [PH_W-1:0]  ofs_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + freq_word;
        end
    end

    assign ofs_ext = PH_W'(ofs) << SH;
    assign phase   = acc_q[ACC_W-1 -: PH_W] + ofs_ext;
    assign acc     = acc_q;
endmodule

// File: rtl/sc_phase_gen.sv
module sc_phase_gen #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 10,
    parameter int OFS_W = 8,
    parameter int ADDR_W = 3,
    parameter int SYNC_N = 2,
    parameter logic [ACC_W-1:0] FREQ_RST = 32'h21F07C1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              sc_pin,
    output logic [PH_W-1:0]   phase_out
);
    logic [ACC_W-1:0]  freq_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              pin_in_en;
    logic              role_sel;
    logic              gl_clr;
    sc_pkg::gl_state_t gl_state;
    logic [ACC_W-1:0]  acc_q;

    sc_freq_regs #(
        .ACC_W(ACC_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .FREQ_RST(FREQ_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .freq_word(freq_q), .ofs(ofs_q),
        .pin_in_en(pin_in_en), .role_sel(role_sel)
    );

    sc_genlock_ctl #(.SYNC_N(SYNC_N)) u_gl (
        .clk(clk), .rst_n(rst_n), .sc_pin(sc_pin), .pin_in_en(pin_in_en),
        .role_sel(role_sel), .clr(gl_clr), .state(gl_state)
    );

    sc_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W), .OFS_W(OFS_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(gl_clr), .freq_word(freq_q),
        .ofs(ofs_q), .acc(acc_q), .phase(phase_out)
    );
endmodule

// File: rtl/sc_phase_gen_chk.sv
module sc_phase_gen_chk #(
    parameter int ACC_W = 32,
    parameter int ADDR_W = 3,
    parameter logic [ACC_W-1:0] FREQ_RST = 32'h21F07C1F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              pin_in_en,
    input logic              role_sel,
    input sc_pkg::gl_state_t gl_state,
    input logic [ACC_W-1:0]  acc_q,
    input logic [ACC_W-1:0]  freq_q
);
    import sc_pkg::*;
    localparam int NBYTES = ACC_W / 8;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (acc_q == '0 && freq_q == FREQ_RST));

    assert_commit_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(NBYTES - 1)) |=> (freq_q[ACC_W-1 -: 8] == $past(wr_data)));

    assert_partial_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr < ADDR_W'(NBYTES - 1)) |=> $stable(freq_q));

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gl_state == GL_CLEAR) |=> (acc_q == '0));

    assert_no_clear_unarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gl_state != GL_ARMED) |=> (gl_state != GL_CLEAR));

    assert_role_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_in_en || role_sel) |=> (gl_state != GL_ARMED));
endmodule

bind sc_phase_gen sc_phase_gen_chk #(
    .ACC_W(ACC_W), .ADDR_W(ADDR_W), .FREQ_RST(FREQ_RST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pin_in_en(pin_in_en), .role_sel(role_sel),
    .gl_state(gl_state), .acc_q(acc_q), .freq_q(freq_q)
);

// File: tb/tb_sc_phase_gen.sv
module tb_sc_phase_gen;
    localparam int CLK_P = 10;
    localparam logic [31:0] DEF_FREQ = 32'h21F07C1F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sc_pin = 1'b0;
    logic [9:0] phase_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    logic [23:0] m_stage;
    logic [31:0] m_freq;
    logic [31:0] m_acc;
    logic [7:0]  m_ofs;
    logic [1:0]  m_mode;
    logic [2:0]  m_sh;
    int          m_st;

    sc_phase_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sc_pin(sc_pin), .phase_out(phase_out)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [9:0] exp_phase();
        return m_acc[31:22] + {m_ofs, 2'b00};
    endfunction

    task automatic model_edge();
        logic en, rise;
        int   nst;
        if (!rst_n) begin
            m_stage = DEF_FREQ[23:0]; m_freq = DEF_FREQ; m_acc = '0;
            m_ofs = '0; m_mode = '0; m_sh = '0; m_st = 0;
            return;
        end
        en   = m_mode[0] & ~m_mode[1];
        rise = m_sh[1] & ~m_sh[2];
        case (m_st)
            0: nst = en ? 1 : 0;
            1: nst = !en ? 0 : (rise ? 2 : 1);
            default: nst = en ? 1 : 0;
        endcase
        m_acc = (m_st == 2) ? 32'd0 : m_acc + m_freq;
        m_st  = nst;
        m_sh  = {m_sh[1:0], sc_pin};
        if (wr_en) begin
            case (wr_addr)
                3'd0: m_stage[7:0]   = wr_data;
                3'd1: m_stage[15:8]  = wr_data;
                3'd2: m_stage[23:16] = wr_data;
                3'd3: m_freq = {wr_data, m_stage};
                3'd4: m_ofs = wr_data;
                3'd5: m_mode = wr_data[1:0];
                default: ;
            endcase
        end
    endtask

    task automatic check_val(string tag, logic [9:0] act, logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: phase_out=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_val(tag, phase_out, exp_phase());
        wr_en = 1'b0;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d, string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(tag);
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; sc_pin = 1'b0;
        tick("R1");
        tick("R1");
        check_val("R1", phase_out, 10'd0);
        rst_n = 1'b1;
        tick("R1");
        check_val("R1", phase_out, 10'd135);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        @(negedge clk);
        do_reset();
        run(20, "R2");

        // R2: wrap with half-scale word
        wr(3'd0, 8'h00, "R2"); wr(3'd1, 8'h00, "R2"); wr(3'd2, 8'h00, "R2");
        wr(3'd3, 8'h80, "R3");
        run(6, "R2");

        // R4: partial writes leave the rate unchanged
        wr(3'd0, 8'hFF, "R4"); wr(3'd1, 8'hFF, "R4"); wr(3'd2, 8'h12, "R4");
        run(10, "R4");
        // R3: MSB commit
        wr(3'd3, 8'h05, "R3");
        run(10, "R3");

        // R5: offset
        wr(3'd4, 8'h40, "R5");
        run(5, "R5");

        // R10: unused addresses
        wr(3'd6, 8'hFF, "R10"); wr(3'd7, 8'hA5, "R10");
        run(3, "R10");

        // R6/R7: reset mode, exact clear edge
        wr(3'd5, 8'h01, "R6");
        run(4, "R6");
        sc_pin = 1'b1;
        run(4, "R7");
        check_val("R7", phase_out, 10'h100);
        run(3, "R7");

        // R8: held high, falling edge, other role, not input
        run(5, "R8");
        sc_pin = 1'b0; run(6, "R8");
        wr(3'd5, 8'h03, "R6");
        sc_pin = 1'b1; run(6, "R8");
        sc_pin = 1'b0; run(2, "R8");
        wr(3'd5, 8'h00, "R8");
        sc_pin = 1'b1; run(6, "R8");
        sc_pin = 1'b0; run(2, "R8");

        // R9: clear and commit on the same edge
        wr(3'd5, 8'h01, "R9");
        run(3, "R9");
        wr(3'd0, 8'h11, "R9"); wr(3'd1, 8'h22, "R9"); wr(3'd2, 8'h33, "R9");
        sc_pin = 1'b1;
        run(3, "R9");
        wr(3'd3, 8'h44, "R9");
        check_val("R9", phase_out, 10'h100);
        tick("R9");
        check_val("R9", phase_out, 10'h100 + 10'(32'h44332211 >> 22));
        run(4, "R9");
        sc_pin = 1'b0;

        // random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 100 < 10) begin
                wr_en = 1'b1;
                wr_addr = 3'($urandom % 8);
                wr_data = 8'($urandom);
            end
            if ($urandom % 12 == 0) sc_pin = ~sc_pin;
            tick("R2");
        end

        // mid-run reset
        do_reset();
        run(4, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule